// File: doc/BRIEF.md
# Half-Flash Converter Conversion Sequencer

This block is a clocked host-side controller that runs an 8-bit half-flash analog-to-digital converter over a parallel strobe bus (chip select, write strobe, read strobe, plus interrupt, ready, data and overflow lines from the converter). A free-running period timer asks for a conversion at fixed intervals. The sequencer then drives the strobes with the converter's minimum pulse widths and delays, captures the 8-bit code and its overflow flag, and hands the result downstream as a one-cycle valid pulse.

Two bus modes are selected per conversion. In write-then-read mode the write strobe samples the input and starts the conversion. The read is then issued either after a fixed early-read delay, ignoring the interrupt, or once the interrupt line goes low. In read-only mode, chip select and read fall together, sample the input, and stay low until the converter releases its ready line.

Every timing limit is a parameter counted in clock cycles. The defaults assume a 100 MHz clock. Interrupt and ready are brought in through two-flop synchronizers. A watchdog aborts any conversion whose completion signal never arrives.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, adc_cs_n, adc_wr_n and adc_rd_n are 1 and res_valid, res_overrun and conv_err are 0.
- R2: In write-then-read mode, adc_wr_n stays low for exactly WR_LOW_CYC cycles per conversion.
- R3: Between the end of one conversion (rise of adc_cs_n) and the next sampling edge (fall of adc_cs_n), at least GAP_CYC cycles pass. A timer request that arrives before the gap is met is held rather than dropped, and the conversion starts once the gap is met.
- R4: With cfg_fast_read=1, adc_rd_n falls exactly FAST_DLY_CYC cycles after adc_wr_n rises, whatever adc_int_n does, and stays low for RD_FAST_CYC cycles.
- R5: With cfg_fast_read=0 in write-then-read mode, adc_rd_n falls only after adc_int_n has gone low (active low), within 4 cycles of it, and stays low for RD_POLL_CYC cycles.
- R6: With cfg_rd_only=1, adc_cs_n and adc_rd_n fall in the same cycle and adc_wr_n stays 1. adc_rd_n stays low until adc_rdy (1 = released) is seen high, then for RD_POLL_CYC to RD_POLL_CYC+4 more cycles.
- R7: Each completed conversion raises res_valid for exactly one cycle. res_data then holds adc_data as read, and res_ovf is 1 when adc_ofl_n was 0 at capture.
- R8: If res_valid is 1 while res_ready is 0, res_overrun becomes 1 and stays 1 until reset.
- R9: If the awaited interrupt (poll option) or ready (read-only mode) does not arrive within TIMEOUT_CYC cycles, the strobes return high, no result is emitted, and conv_err becomes 1 and stays 1 until reset.
- R10: While seq_enable is 1 and each conversion plus gap fits in PERIOD_CYC, sampling edges come exactly PERIOD_CYC cycles apart. While seq_enable is 0, no conversion starts.
- R11: cfg_rd_only and cfg_fast_read are sampled when a conversion starts. A change during a conversion affects only the next one.
- R12: adc_cs_n is 0 whenever adc_wr_n or adc_rd_n is 0, and adc_wr_n and adc_rd_n are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seq_enable | input | 1 | Runs the period timer; 0 stops new conversions |
| cfg_rd_only | input | 1 | 1 = read-only mode, 0 = write-then-read |
| cfg_fast_read | input | 1 | Write-then-read: 1 = fixed early read, 0 = wait for interrupt |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Converter write strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_int_n | input | 1 | Converter conversion-done flag, active low, asynchronous |
| adc_rdy | input | 1 | Converter ready, 0 while converting, 1 when released, asynchronous |
| adc_data | input | DATA_W | Converter data bus |
| adc_ofl_n | input | 1 | Converter overflow, active low |
| res_valid | output | 1 | One-cycle result strobe |
| res_ready | input | 1 | Consumer can take the result |
| res_data | output | DATA_W | Captured code |
| res_ovf | output | 1 | Captured overflow flag, active high |
| res_overrun | output | 1 | Sticky: a result was offered while the consumer was not ready |
| conv_err | output | 1 | Sticky: a conversion was aborted by the watchdog |

## Verification
The assertions assume three things about the converter. It pulls adc_rdy low within RDY_BLANK_CYC cycles of the read strobe falling. It drops adc_int_n only after the write strobe rises and lets it go when the read ends. The timer period is long enough that results are never closer than two cycles apart. The bench's converter model keeps to this: the interrupt falls 40 cycles after the write rises and is released on the read rise, and ready drops half a cycle after chip select and is released 70 cycles later. The bench keeps the default period of 120 cycles, which is longer than any full conversion plus gap, so only deliberate aborts push a request past its tick.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,     // gap / tracking time, strobes high
    ST_WR_LOW,   // write strobe low, input sampled at entry
    ST_WR_WAIT,  // between write rise and read fall
    ST_RD_LOW,   // read strobe low in write-then-read mode
    ST_RO_WAIT,  // read-only: strobe low, waiting for ready
    ST_RO_HOLD   // read-only: ready seen, data access time
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int unsigned STAGES  = 2,   // at least 2
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned PERIOD_CYC = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_ack,
  output logic start_req
);
  localparam int unsigned PW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;

  logic [PW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          tick;

  always_comb begin
    tick   = enable && (cnt_q == PW'(PERIOD_CYC - 1));
    cnt_d  = (!enable || tick) ? '0 : cnt_q + 1'b1;
    pend_d = enable && (tick || (pend_q && !start_ack));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign start_req = pend_q;

  // R3
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ack |-> start_req)
    else $error("start accepted without a pending request");

  // R10
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !start_req) |=> !start_req)
    else $error("request raised while disabled");
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned WR_LOW_CYC    = 25,
  parameter int unsigned GAP_CYC       = 35,
  parameter int unsigned FAST_DLY_CYC  = 25,
  parameter int unsigned RD_FAST_CYC   = 16,
  parameter int unsigned RD_POLL_CYC   = 7,
  parameter int unsigned RDY_BLANK_CYC = 12,
  parameter int unsigned TIMEOUT_CYC   = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic start_ack,
  input  logic cfg_rd_only,
  input  logic cfg_fast_read,
  input  logic int_n_s,
  input  logic rdy_s,
  output logic cs_n,
  output logic wr_n,
  output logic rd_n,
  output logic cap_en,
  output logic conv_err
);
  localparam int unsigned CMAX = max2(max2(max2(WR_LOW_CYC, GAP_CYC), max2(FAST_DLY_CYC, RD_FAST_CYC)),
                                      max2(max2(RD_POLL_CYC, RDY_BLANK_CYC), TIMEOUT_CYC));
  localparam int unsigned CW   = $clog2(CMAX + 1);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q, mode_d, fast_q, fast_d;
  logic          cs_n_q, wr_n_q, rd_n_q, err_q, err_d;
  logic          tmo;
  logic [CW-1:0] rd_last;
  logic          gap_ok;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q + 1'b1;
    mode_d    = mode_q;
    fast_d    = fast_q;
    start_ack = 1'b0;
    cap_en    = 1'b0;
    tmo       = 1'b0;
    rd_last   = fast_q ? CW'(RD_FAST_CYC - 1) : CW'(RD_POLL_CYC - 1);
    gap_ok    = (cnt_q >= CW'(GAP_CYC - 1));
    unique case (st_q)
      ST_IDLE: begin
        if (gap_ok) cnt_d = cnt_q;
        if (start_req && gap_ok) begin
          start_ack = 1'b1;
          mode_d    = cfg_rd_only;
          fast_d    = cfg_fast_read;
          cnt_d     = '0;
          st_d      = cfg_rd_only ? ST_RO_WAIT : ST_WR_LOW;
        end
      end
      ST_WR_LOW: begin
        if (cnt_q == CW'(WR_LOW_CYC - 1)) begin
          st_d  = ST_WR_WAIT;
          cnt_d = '0;
        end
      end
      ST_WR_WAIT: begin
        if (fast_q) begin
          if (cnt_q == CW'(FAST_DLY_CYC - 1)) begin
            st_d  = ST_RD_LOW;
            cnt_d = '0;
          end
        end else if (!int_n_s) begin
          st_d  = ST_RD_LOW;
          cnt_d = '0;
        end else if (cnt_q == CW'(TIMEOUT_CYC - 1)) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
          tmo   = 1'b1;
        end
      end
      ST_RD_LOW: begin
        if (cnt_q == rd_last) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          cap_en = 1'b1;
        end
      end
      ST_RO_WAIT: begin
        if (rdy_s && (cnt_q >= CW'(RDY_BLANK_CYC - 1))) begin
          st_d  = ST_RO_HOLD;
          cnt_d = '0;
        end else if (cnt_q == CW'(TIMEOUT_CYC - 1)) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
          tmo   = 1'b1;
        end
      end
      ST_RO_HOLD: begin
        if (cnt_q == CW'(RD_POLL_CYC - 1)) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          cap_en = 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
    err_d = err_q | tmo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      fast_q <= 1'b0;
      cs_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      rd_n_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      fast_q <= fast_d;
      cs_n_q <= (st_d == ST_IDLE);
      wr_n_q <= (st_d != ST_WR_LOW);
      rd_n_q <= !(st_d inside {ST_RD_LOW, ST_RO_WAIT, ST_RO_HOLD});
      err_q  <= err_d;
    end
  end

  assign cs_n     = cs_n_q;
  assign wr_n     = wr_n_q;
  assign rd_n     = rd_n_q;
  assign conv_err = err_q;

  // Checker-only run-length counters for pulse widths on the ports.
  logic [CW-1:0] hi_run_q, wr_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      wr_run_q <= '0;
    end else begin
      if (!cs_n_q)                         hi_run_q <= '0;
      else if (hi_run_q != CW'(GAP_CYC))   hi_run_q <= hi_run_q + 1'b1;
      if (wr_n_q)                          wr_run_q <= '0;
      else if (wr_run_q != CW'(CMAX))      wr_run_q <= wr_run_q + 1'b1;
    end
  end

  // R12
  cs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_q || !rd_n_q) |-> !cs_n_q)
    else $error("strobe low without chip select");

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n_q && !rd_n_q))
    else $error("write and read low together");

  // R2
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n_q) |-> (wr_run_q == CW'(WR_LOW_CYC)))
    else $error("write low width wrong");

  // R3
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (hi_run_q >= CW'(GAP_CYC)))
    else $error("conversion started inside the gap");

  // R6
  ro_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !cs_n_q) |-> wr_n_q)
    else $error("write strobe in read-only mode");

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q)
    else $error("error flag cleared");
endmodule

// File: rtl/adc_seq_out.sv
module adc_seq_out #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_ofl_n,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ovf,
  output logic              res_overrun
);
  logic              vld_q, ovr_q, ovr_d, ovf_q;
  logic [DATA_W-1:0] dat_q;

  always_comb ovr_d = ovr_q | (vld_q & !res_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ovr_q <= 1'b0;
      ovf_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= cap_en;
      ovr_q <= ovr_d;
      if (cap_en) begin
        dat_q <= adc_data;
        ovf_q <= !adc_ofl_n;
      end
    end
  end

  assign res_valid   = vld_q;
  assign res_data    = dat_q;
  assign res_ovf     = ovf_q;
  assign res_overrun = ovr_q;

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid)
    else $error("valid longer than one cycle");

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_overrun)
    else $error("overrun not flagged");

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_overrun |=> res_overrun)
    else $error("overrun flag cleared");
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned PERIOD_CYC    = 120,
  parameter int unsigned WR_LOW_CYC    = 25,
  parameter int unsigned GAP_CYC       = 35,
  parameter int unsigned FAST_DLY_CYC  = 25,
  parameter int unsigned RD_FAST_CYC   = 16,
  parameter int unsigned RD_POLL_CYC   = 7,
  parameter int unsigned RDY_BLANK_CYC = 12,
  parameter int unsigned TIMEOUT_CYC   = 150,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_enable,
  input  logic              cfg_rd_only,
  input  logic              cfg_fast_read,
  output logic              adc_cs_n,
  output logic              adc_wr_n,
  output logic              adc_rd_n,
  input  logic              adc_int_n,
  input  logic              adc_rdy,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_ofl_n,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ovf,
  output logic              res_overrun,
  output logic              conv_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       start_req, start_ack, int_n_s, rdy_s, cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  adc_seq_timer #(.PERIOD_CYC(PERIOD_CYC)) i_timer (
    .clk(clk), .rst_n(rst_int_n), .enable(seq_enable),
    .start_ack(start_ack), .start_req(start_req));

  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_int_sync (
    .clk(clk), .rst_n(rst_int_n), .d(adc_int_n), .q(int_n_s));

  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rdy_sync (
    .clk(clk), .rst_n(rst_int_n), .d(adc_rdy), .q(rdy_s));

  adc_seq_fsm #(
    .WR_LOW_CYC(WR_LOW_CYC), .GAP_CYC(GAP_CYC), .FAST_DLY_CYC(FAST_DLY_CYC),
    .RD_FAST_CYC(RD_FAST_CYC), .RD_POLL_CYC(RD_POLL_CYC),
    .RDY_BLANK_CYC(RDY_BLANK_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_fsm (
    .clk(clk), .rst_n(rst_int_n), .start_req(start_req), .start_ack(start_ack),
    .cfg_rd_only(cfg_rd_only), .cfg_fast_read(cfg_fast_read),
    .int_n_s(int_n_s), .rdy_s(rdy_s),
    .cs_n(adc_cs_n), .wr_n(adc_wr_n), .rd_n(adc_rd_n),
    .cap_en(cap_en), .conv_err(conv_err));

  adc_seq_out #(.DATA_W(DATA_W)) i_out (
    .clk(clk), .rst_n(rst_int_n), .cap_en(cap_en),
    .adc_data(adc_data), .adc_ofl_n(adc_ofl_n), .res_ready(res_ready),
    .res_valid(res_valid), .res_data(res_data), .res_ovf(res_ovf),
    .res_overrun(res_overrun));
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD  = 120;
  localparam int WR_LOW  = 25;
  localparam int GAP     = 35;
  localparam int FAST    = 25;
  localparam int RD_FAST = 16;
  localparam int RD_POLL = 7;
  localparam int TMO     = 150;
  localparam int INT_DLY = 40;
  localparam int RDY_DLY = 70;

  logic clk = 1'b0;
  logic rst_n, seq_enable, cfg_rd_only, cfg_fast_read;
  logic adc_cs_n, adc_wr_n, adc_rd_n;
  logic adc_int_n, adc_rdy, adc_ofl_n;
  logic [7:0] adc_data, res_data;
  logic res_valid, res_ready, res_ovf, res_overrun, conv_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(
    .DATA_W(8), .PERIOD_CYC(PERIOD), .WR_LOW_CYC(WR_LOW), .GAP_CYC(GAP),
    .FAST_DLY_CYC(FAST), .RD_FAST_CYC(RD_FAST), .RD_POLL_CYC(RD_POLL),
    .RDY_BLANK_CYC(12), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
  ) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .seq_enable(seq_enable),
    .cfg_rd_only(cfg_rd_only), .cfg_fast_read(cfg_fast_read),
    .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
    .adc_int_n(adc_int_n), .adc_rdy(adc_rdy), .adc_data(adc_data),
    .adc_ofl_n(adc_ofl_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_ovf(res_ovf), .res_overrun(res_overrun),
    .conv_err(conv_err));

  int errors = 0, checks = 0;
  bit done = 0;

  // converter model controls
  logic [7:0] drive_code = 8'h00;
  logic       drive_ovf = 1'b0;
  bit         int_en = 1, rdy_en = 1;

  // monitor state
  int cyc = 0, last_start = 0, prev_start = 0, last_gap = 0, cs_rise_t = 0;
  int wr_rise_t = 0, wr_lo = 0, wr_len = 0, wr_falls = 0;
  int rd_fall_t = 0, rd_rise_t = 0, rd_lo = 0, rd_len = 0;
  int int_fall_t = 0, rdy_rise_t = 0, res_cnt = 0, int_cnt = 0, rdy_cnt = 0;
  logic [7:0] last_code = 8'h00, smp_code = 8'h00;
  logic last_ovf = 1'b0, smp_ovf = 1'b0;
  logic p_cs = 1'b1, p_wr = 1'b1, p_rd = 1'b1;
  bit int_arm = 0, ro_act = 0;

  initial begin
    adc_int_n = 1'b1; adc_rdy = 1'b1; adc_data = 8'h00; adc_ofl_n = 1'b1;
  end

  // Converter model and port monitor, both at the falling clock edge.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!adc_cs_n && p_cs) begin
        prev_start = last_start; last_start = cyc; last_gap = cyc - cs_rise_t;
        wr_falls = 0; smp_code = drive_code; smp_ovf = drive_ovf;
        adc_int_n = 1'b1; ro_act = !adc_rd_n; rdy_cnt = 0;
        if (ro_act) adc_rdy = 1'b0;
      end
      if (adc_cs_n && !p_cs) begin cs_rise_t = cyc; int_arm = 0; end
      if (!adc_wr_n && p_wr) begin wr_falls++; wr_lo = 0; end
      if (!adc_wr_n) wr_lo++;
      if (adc_wr_n && !p_wr) begin wr_len = wr_lo; wr_rise_t = cyc; int_arm = 1; int_cnt = 0; end
      if (!adc_rd_n && p_rd) begin rd_fall_t = cyc; rd_lo = 0; end
      if (!adc_rd_n) rd_lo++;
      if (adc_rd_n && !p_rd) begin rd_len = rd_lo; rd_rise_t = cyc; adc_int_n = 1'b1; int_arm = 0; end
      if (res_valid) begin res_cnt++; last_code = res_data; last_ovf = res_ovf; end
      if (int_arm) begin
        int_cnt++;
        if (int_cnt >= INT_DLY && int_en && adc_int_n) begin adc_int_n = 1'b0; int_fall_t = cyc; end
      end
      if (ro_act && !adc_cs_n) begin
        rdy_cnt++;
        if (rdy_cnt >= RDY_DLY && rdy_en && !adc_rdy) begin adc_rdy = 1'b1; rdy_rise_t = cyc; end
      end
      if (adc_cs_n) begin adc_rdy = 1'b1; ro_act = 0; end
      adc_data  = !adc_rd_n ? smp_code : 8'h00;
      adc_ofl_n = !adc_rd_n ? !smp_ovf : 1'b1;
      p_cs = adc_cs_n; p_wr = adc_wr_n; p_rd = adc_rd_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_end();
    @(posedge adc_cs_n);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1 strobes high in reset",
        {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
    chk(!res_valid && !res_overrun && !conv_err, "R1 flags low in reset",
        {res_valid, res_overrun, conv_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(adc_cs_n && adc_wr_n && adc_rd_n && !res_valid, "R1 idle after release",
        {adc_cs_n, adc_wr_n, adc_rd_n, res_valid}, 14);
  endtask

  task automatic t_fast();
    cfg_rd_only = 1'b0; cfg_fast_read = 1'b1; int_en = 0;
    drive_code = 8'h5A; drive_ovf = 1'b0;
    seq_enable = 1'b1;
    wait_end();
    chk(wr_len == WR_LOW, "R2 write width", wr_len, WR_LOW);
    chk(rd_fall_t - wr_rise_t == FAST, "R4 early read delay with interrupt idle",
        rd_fall_t - wr_rise_t, FAST);
    chk(rd_len == RD_FAST, "R4 early read width", rd_len, RD_FAST);
    chk(last_code == 8'h5A && !last_ovf, "R7 fast result", last_code, 8'h5A);
    chk(!conv_err, "R9 no error without timeout", conv_err, 0);
    int_en = 1;
  endtask

  task automatic t_poll();
    cfg_fast_read = 1'b0; drive_code = 8'hC3; drive_ovf = 1'b1;
    wait_end();
    chk(rd_fall_t > int_fall_t && int_fall_t > wr_rise_t, "R5 read after interrupt",
        rd_fall_t, int_fall_t + 1);
    chk(rd_fall_t - int_fall_t <= 4, "R5 read latency", rd_fall_t - int_fall_t, 4);
    chk(rd_len == RD_POLL, "R5 polled read width", rd_len, RD_POLL);
    chk(last_code == 8'hC3 && last_ovf, "R7 overflow result", {last_ovf, last_code}, 9'h1C3);
  endtask

  task automatic t_ro();
    cfg_rd_only = 1'b1; drive_code = 8'hFF; drive_ovf = 1'b1;
    wait_end();
    chk(wr_falls == 0, "R6 no write in read-only", wr_falls, 0);
    chk(rd_fall_t == last_start, "R6 read falls with select", rd_fall_t, last_start);
    chk(rd_rise_t - rdy_rise_t >= RD_POLL && rd_rise_t - rdy_rise_t <= RD_POLL + 4,
        "R6 hold after ready", rd_rise_t - rdy_rise_t, RD_POLL + 3);
    chk(last_code == 8'hFF && last_ovf, "R7 read-only result", last_code, 8'hFF);
  endtask

  task automatic t_period();
    cfg_rd_only = 1'b0; cfg_fast_read = 1'b1;
    for (int i = 0; i < 3; i++) begin
      drive_code = 8'(8'h10 + i); drive_ovf = 1'b0;
      wait_end();
      chk(last_start - prev_start == PERIOD, "R10 equal sample spacing",
          last_start - prev_start, PERIOD);
      chk(last_gap >= GAP, "R3 gap before sampling", last_gap, GAP);
      chk(last_code == 8'(8'h10 + i), "R7 streamed code", last_code, 8'h10 + i);
    end
  endtask

  task automatic t_mode_change();
    cfg_rd_only = 1'b0; cfg_fast_read = 1'b1; drive_code = 8'h81;
    @(negedge adc_wr_n);
    @(negedge clk);
    cfg_rd_only = 1'b1; cfg_fast_read = 1'b0;
    wait_end();
    chk(wr_falls == 1 && rd_len == RD_FAST, "R11 mode held during conversion",
        rd_len, RD_FAST);
    chk(last_code == 8'h81, "R11 result of started mode", last_code, 8'h81);
    drive_code = 8'h42; drive_ovf = 1'b0;
    wait_end();
    chk(wr_falls == 0 && last_code == 8'h42, "R11 new mode on next start",
        wr_falls, 0);
    cfg_rd_only = 1'b0; cfg_fast_read = 1'b1;
  endtask

  task automatic t_disable();
    int s0;
    seq_enable = 1'b0;
    s0 = last_start;
    repeat (400) @(negedge clk);
    chk(last_start == s0 && adc_cs_n, "R10 no start while disabled", last_start, s0);
    seq_enable = 1'b1;
  endtask

  task automatic t_overrun();
    chk(!res_overrun, "R8 overrun clear before stall", res_overrun, 0);
    res_ready = 1'b0; drive_code = 8'h3C;
    wait_end();
    chk(res_overrun, "R8 overrun on stalled consumer", res_overrun, 1);
    chk(last_code == 8'h3C, "R7 result offered while stalled", last_code, 8'h3C);
    res_ready = 1'b1;
    wait_end();
    chk(res_overrun, "R8 overrun sticky", res_overrun, 1);
  endtask

  task automatic t_timeout_poll();
    int c0;
    cfg_fast_read = 1'b0; int_en = 0; c0 = res_cnt;
    wait_end();
    chk(conv_err, "R9 error on missing interrupt", conv_err, 1);
    chk(res_cnt == c0, "R9 no result after abort", res_cnt, c0);
    chk(adc_wr_n && adc_rd_n && adc_cs_n, "R9 strobes released",
        {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
    int_en = 1; drive_code = 8'h99;
    wait_end();
    chk(last_gap >= GAP, "R3 gap after abort", last_gap, GAP);
    chk(last_start - prev_start > PERIOD && last_start - prev_start < 2 * PERIOD,
        "R3 held request starts after gap", last_start - prev_start, PERIOD + 1);
    chk(last_code == 8'h99, "R3 held conversion delivered", last_code, 8'h99);
  endtask

  task automatic t_timeout_ro();
    int c0;
    cfg_rd_only = 1'b1; rdy_en = 0; c0 = res_cnt;
    wait_end();
    chk(res_cnt == c0, "R9 no result on missing ready", res_cnt, c0);
    chk(conv_err && adc_rd_n && adc_cs_n, "R9 read-only abort", conv_err, 1);
    rdy_en = 1; drive_code = 8'h07;
    wait_end();
    chk(last_code == 8'h07 && conv_err, "R9 recovery keeps sticky error", last_code, 8'h07);
  endtask

  initial begin
    rst_n = 1'b0; seq_enable = 1'b0; cfg_rd_only = 1'b0; cfg_fast_read = 1'b1;
    res_ready = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_fast();
    t_poll();
    t_ro();
    t_period();
    t_mode_change();
    t_disable();
    t_overrun();
    t_timeout_poll();
    t_timeout_ro();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule